// File: doc/BRIEF.md
# Interrupt status and mask unit

This block keeps the interrupt status and interrupt mask registers of a memory-mapped storage adapter. Internal events set one of two status flags: a command-completion flag and an asynchronous-message flag. Software reads both registers over a simple 32-bit word interface. It clears status flags by writing ones to them, and it loads the mask by writing the whole word.

The interrupt condition is true when the mask and the status have at least one set bit in common. With message-signalled mode off, the block drives that condition on a level line. With the mode on, the level line stays low. Instead, the block sends a one-cycle notification pulse, but only at an evaluation point where the condition is true. An evaluation point is any status write, mask write, completion event or message event.

A status write also asks for completion processing to resume when completions are still queued. An adapter reset clears the status and leaves the mask as it was.

Top module: `irq_status_unit`

## Requirements
- R1: After rst_ni is released, both registers read 0, and irq_level_o, msi_pulse_o and resume_cmp_o are low.
- R2: cmpl_evt_i sets status bit 0 and msg_evt_i sets status bit 12, each from the next clock edge. All other status bits always read 0.
- R3: A write to the status offset clears each status bit whose written bit is 1, and leaves every other bit unchanged.
- R4: A write to the mask offset replaces all 32 mask bits with the written word, and a read returns that word.
- R5: With msi_mode_i low, irq_level_o equals the OR-reduction of (mask AND status), updated in the cycle after the event or write that changed either register. msi_pulse_o stays low.
- R6: With msi_mode_i high, irq_level_o is low. msi_pulse_o is high for one cycle, in the cycle after an evaluation point, exactly when (mask AND status) is non-zero after that evaluation point. An evaluation point is a status write, a mask write, cmpl_evt_i or msg_evt_i.
- R7: A status write while cmp_pending_i is high gives a one-cycle resume_cmp_o pulse in the next cycle. A status write with cmp_pending_i low, or a mask write, gives no pulse.
- R8: adp_rst_i clears the status at the next edge and overrides any event or write in the same cycle. The mask keeps its value.
- R9: When a set event and a status write that clears the same bit fall in the same cycle, the bit ends set.
- R10: The registers are 4-byte words, little-endian, and use byte offsets: status at 0x08, mask at 0x0C. A read of any other offset returns 0, and a write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msi_mode_i | input | 1 | Message-signalled mode enable |
| adp_rst_i | input | 1 | Adapter reset, clears status |
| cmpl_evt_i | input | 1 | Completion event, sets status bit 0 |
| msg_evt_i | input | 1 | Message event, sets status bit 12 |
| cmp_pending_i | input | 1 | Completions still queued |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_level_o | output | 1 | Level interrupt line |
| msi_pulse_o | output | 1 | Message-signalled notification pulse |
| resume_cmp_o | output | 1 | Request to resume completion processing |

## Verification
Two functions can fall in the same cycle and compete for the same status bit: a completion event and a software write-one-to-clear of that bit. The bench provokes this with one cycle that carries both the event and an all-ones status write, and it expects the bit to read back as set. It also provokes an adapter reset in the same cycle as both events and checks that the status reads 0 while the mask is unchanged. Around these collisions it sweeps every status combination against several mask patterns in both output modes. For each step it computes the expected level, pulse and readback from the mask AND status arithmetic.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_map.sv
module irq_addr_map
  import irq_unit_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              wr_status_o,
  output logic              wr_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;

  always_comb begin
    if (addr_i == STATUS_OFS)    sel = SEL_STATUS;
    else if (addr_i == MASK_OFS) sel = SEL_MASK;
    else                         sel = SEL_NONE;
  end

  assign wr_status_o = wr_en_i && (sel == SEL_STATUS);
  assign wr_mask_o   = wr_en_i && (sel == SEL_MASK);

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_i;
      SEL_MASK:   rdata_o = mask_i;
      default:    rdata_o = '0;
    endcase
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != STATUS_OFS && addr_i != MASK_OFS) |-> (rdata_o == '0)); // R10
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int DATA_W   = 32,
  parameter int CMPL_BIT = 0,
  parameter int MSG_BIT  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adp_rst_i,
  input  logic              cmpl_evt_i,
  input  logic              msg_evt_i,
  input  logic              wr_status_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              cond_next_o,
  output logic              eval_o
);
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] mask_q, mask_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == CMPL_BIT || i == MSG_BIT) begin : g_impl
      logic set_b, bit_d, bit_q;
      assign set_b = (i == CMPL_BIT) ? cmpl_evt_i : msg_evt_i;
      // priority: adapter reset > set event > write-one-to-clear
      always_comb begin
        bit_d = bit_q;
        if (wr_status_i && wdata_i[i]) bit_d = 1'b0;
        if (set_b)                     bit_d = 1'b1;
        if (adp_rst_i)                 bit_d = 1'b0;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= bit_d;
      end
      assign status_d[i] = bit_d;
      assign status_o[i] = bit_q;
    end else begin : g_tie
      assign status_d[i] = 1'b0;
      assign status_o[i] = 1'b0;
    end
  end

  assign mask_d = wr_mask_i ? wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o      = mask_q;
  assign cond_next_o = |(mask_d & status_d);
  assign eval_o      = wr_status_i | wr_mask_i | cmpl_evt_i | msg_evt_i;

  AST_MASK_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_o == $past(wdata_i))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o)); // R8
  AST_ADP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adp_rst_i |=> (status_o == '0)); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_evt_i && !adp_rst_i) |=> status_o[CMPL_BIT]); // R9
  AST_MSG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_evt_i && !adp_rst_i) |=> status_o[MSG_BIT]); // R2
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status_i && wdata_i[CMPL_BIT] && !cmpl_evt_i) |=> !status_o[CMPL_BIT]); // R3
endmodule

// File: rtl/irq_notify.sv
module irq_notify #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_mode_i,
  input  logic              eval_i,
  input  logic              cond_next_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              wr_status_i,
  input  logic              cmp_pending_i,
  output logic              irq_level_o,
  output logic              msi_pulse_o,
  output logic              resume_o
);
  logic cond_q, pulse_q, resume_q;

  assign cond_q      = |(mask_i & status_i);
  assign irq_level_o = cond_q & ~msi_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      pulse_q  <= msi_mode_i & eval_i & cond_next_i;
      resume_q <= wr_status_i & cmp_pending_i;
    end
  end

  assign msi_pulse_o = pulse_q;
  assign resume_o    = resume_q;

  AST_PULSE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_pulse_o |-> cond_q); // R6
  AST_NO_PULSE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msi_mode_i && !$past(msi_mode_i)) |-> !msi_pulse_o); // R5
  AST_RESUME_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_status_i |=> !resume_o); // R7
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter int          CMPL_BIT   = 0,
  parameter int          MSG_BIT    = 12,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] MASK_OFS   = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msi_mode_i,
  input  logic              adp_rst_i,
  input  logic              cmpl_evt_i,
  input  logic              msg_evt_i,
  input  logic              cmp_pending_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_level_o,
  output logic              msi_pulse_o,
  output logic              resume_cmp_o
);
  logic              wr_status, wr_mask, cond_next, eval;
  logic [DATA_W-1:0] status, mask;

  irq_addr_map #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .status_i(status), .mask_i(mask),
    .wr_status_o(wr_status), .wr_mask_o(wr_mask), .rdata_o(rdata_o)
  );

  irq_regs #(
    .DATA_W(DATA_W), .CMPL_BIT(CMPL_BIT), .MSG_BIT(MSG_BIT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .adp_rst_i(adp_rst_i),
    .cmpl_evt_i(cmpl_evt_i), .msg_evt_i(msg_evt_i),
    .wr_status_i(wr_status), .wr_mask_i(wr_mask), .wdata_i(wdata_i),
    .status_o(status), .mask_o(mask), .cond_next_o(cond_next), .eval_o(eval)
  );

  irq_notify #(.DATA_W(DATA_W)) u_notify (
    .clk_i(clk_i), .rst_ni(rst_ni), .msi_mode_i(msi_mode_i),
    .eval_i(eval), .cond_next_i(cond_next), .status_i(status), .mask_i(mask),
    .wr_status_i(wr_status), .cmp_pending_i(cmp_pending_i),
    .irq_level_o(irq_level_o), .msi_pulse_o(msi_pulse_o), .resume_o(resume_cmp_o)
  );
endmodule

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  localparam logic [7:0] ST_OFS = 8'h08;
  localparam logic [7:0] MK_OFS = 8'h0C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msi_mode_i = 1'b0, adp_rst_i = 1'b0, cmpl_evt_i = 1'b0;
  logic        msg_evt_i = 1'b0, cmp_pending_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_level_o, msi_pulse_o, resume_cmp_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] es, em;

  always #4 clk_i = ~clk_i;

  irq_status_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .msi_mode_i(msi_mode_i), .adp_rst_i(adp_rst_i),
    .cmpl_evt_i(cmpl_evt_i), .msg_evt_i(msg_evt_i), .cmp_pending_i(cmp_pending_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_level_o(irq_level_o), .msi_pulse_o(msi_pulse_o), .resume_cmp_o(resume_cmp_o)
  );

  function automatic logic cond(input logic [31:0] s, input logic [31:0] m);
    return (s & m) != 32'h0;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(rq, rdata_o, exp);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic check_outs(input string rq);
    chk({rq, " level"}, {31'b0, irq_level_o}, {31'b0, ~msi_mode_i & cond(es, em)});
    chk({rq, " pulse"}, {31'b0, msi_pulse_o}, {31'b0, msi_mode_i & cond(es, em)});
  endtask

  function automatic logic [31:0] mpat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_1000;
      3: return 32'h0000_1001;
      4: return 32'hFFFF_FFFF;
      default: return 32'hFFFF_EFFE;
    endcase
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    es = '0; em = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd_chk("R1 status", ST_OFS, 32'h0);
    rd_chk("R1 mask", MK_OFS, 32'h0);
    chk("R1 level", {31'b0, irq_level_o}, 32'h0);
    chk("R1 pulse", {31'b0, msi_pulse_o}, 32'h0);
    chk("R1 resume", {31'b0, resume_cmp_o}, 32'h0);

    // sweep: mode x mask pattern x status combination
    for (int mode = 0; mode < 2; mode++) begin
      msi_mode_i = mode[0];
      for (int mi = 0; mi < 6; mi++) begin
        for (int st = 1; st < 4; st++) begin
          @(negedge clk_i);
          adp_rst_i = 1'b1;
          @(negedge clk_i);
          adp_rst_i = 1'b0;
          es = '0;
          rd_chk("R8 status cleared", ST_OFS, 32'h0);
          em = mpat(mi);
          do_write(MK_OFS, em);
          check_outs("R6 R5 after mask write");
          rd_chk("R4 mask readback", MK_OFS, em);
          cmpl_evt_i = st[0]; msg_evt_i = st[1];
          @(negedge clk_i);
          cmpl_evt_i = 1'b0; msg_evt_i = 1'b0;
          es = {19'b0, st[1], 11'b0, st[0]};
          check_outs("R5 R6 after events");
          rd_chk("R2 status set", ST_OFS, es);
          @(negedge clk_i);
          chk("R6 pulse one cycle", {31'b0, msi_pulse_o}, 32'h0);
          cmp_pending_i = st[0];
          do_write(ST_OFS, (st == 3) ? 32'h0000_1000 : 32'hFFFF_FFFF);
          es = (st == 3) ? 32'h0000_0001 : 32'h0;
          check_outs("R3 R6 after clear");
          chk("R7 resume", {31'b0, resume_cmp_o}, {31'b0, st[0]});
          rd_chk("R3 status after clear", ST_OFS, es);
          cmp_pending_i = 1'b0;
          @(negedge clk_i);
          chk("R7 resume one cycle", {31'b0, resume_cmp_o}, 32'h0);
        end
      end
    end

    // R9: set and clear of the same bit in one cycle
    msi_mode_i = 1'b0;
    @(negedge clk_i);
    adp_rst_i = 1'b1;
    @(negedge clk_i);
    adp_rst_i = 1'b0;
    wr_en_i = 1'b1; addr_i = ST_OFS; wdata_i = 32'hFFFF_FFFF; cmpl_evt_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; cmpl_evt_i = 1'b0;
    rd_chk("R9 set wins", ST_OFS, 32'h0000_0001);

    // R8: adapter reset beats events, mask kept
    do_write(MK_OFS, 32'h0000_1001);
    adp_rst_i = 1'b1; cmpl_evt_i = 1'b1; msg_evt_i = 1'b1;
    @(negedge clk_i);
    adp_rst_i = 1'b0; cmpl_evt_i = 1'b0; msg_evt_i = 1'b0;
    rd_chk("R8 reset priority", ST_OFS, 32'h0);
    rd_chk("R8 mask retained", MK_OFS, 32'h0000_1001);
    chk("R8 level low", {31'b0, irq_level_o}, 32'h0);

    // R7: mask write with completions pending gives no resume
    cmp_pending_i = 1'b1;
    do_write(MK_OFS, 32'h0000_1001);
    chk("R7 no resume on mask write", {31'b0, resume_cmp_o}, 32'h0);
    cmp_pending_i = 1'b0;

    // R6: mask writes as evaluation points in message mode
    msi_mode_i = 1'b1;
    msg_evt_i = 1'b1;
    @(negedge clk_i);
    msg_evt_i = 1'b0;
    chk("R6 pulse on msg event", {31'b0, msi_pulse_o}, 32'h1);
    do_write(MK_OFS, 32'h0000_0001);
    chk("R6 no pulse masked", {31'b0, msi_pulse_o}, 32'h0);
    do_write(MK_OFS, 32'h0000_1000);
    chk("R6 pulse on mask write", {31'b0, msi_pulse_o}, 32'h1);
    do_write(MK_OFS, 32'h0000_1000);
    chk("R6 pulse on repeat mask write", {31'b0, msi_pulse_o}, 32'h1);
    chk("R6 level low in msg mode", {31'b0, irq_level_o}, 32'h0);
    msi_mode_i = 1'b0;
    #1;
    chk("R5 level on mode off", {31'b0, irq_level_o}, 32'h1);

    // R10: unmapped offsets
    rd_chk("R10 read 0x00", 8'h00, 32'h0);
    rd_chk("R10 read 0x04", 8'h04, 32'h0);
    rd_chk("R10 read 0x09", 8'h09, 32'h0);
    rd_chk("R10 read 0x10", 8'h10, 32'h0);
    rd_chk("R10 read 0xFF", 8'hFF, 32'h0);
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h0D, 32'h0000_0000);
    do_write(8'h09, 32'hFFFF_FFFF);
    rd_chk("R10 mask untouched", MK_OFS, 32'h0000_1000);
    rd_chk("R10 status untouched", ST_OFS, 32'h0000_1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule